// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a minimal stored-program processor. Its state is a 16-bit accumulator, a 12-bit program counter, a 16-bit instruction register and a one-bit phase flag. One adder-based ALU does all the arithmetic. There is no separate program-counter incrementer: the ALU increments the fetch address, and it also supplies the zero that clears the counter at reset.

The core has a single memory port. It carries a 12-bit word address, separate read and write data buses, a request strobe and a read/write select. The memory sits outside the block and answers reads in the same cycle. Each cycle of the core makes at most one memory access, so an instruction takes exactly as many cycles as it has memory accesses. Loads, stores and arithmetic take one operand cycle plus one fetch cycle. Jumps, and the unused opcodes, take a single cycle, because their work is the fetch of the next instruction.

A stop instruction ends the program. From then on the core makes no memory requests and raises a halted flag, and it stays that way until the next reset.

Top module: `acc16_core`

## Requirements
- R1: While reset is high, mem_req is 0. The reset clears the program counter and halted. In the first cycle after reset, the core reads address 0.
- R2: In a fetch cycle, the core reads the word at the program counter into the instruction register. The counter becomes that address plus one, and the next cycle executes the new instruction.
- R3: Bits 15:12 of an instruction word hold the opcode and bits 11:0 hold the operand address S. The opcodes are: 0 load, 1 store, 2 add, 3 subtract, 4 jump, 5 jump if non-negative, 6 jump if non-zero, 7 stop.
- R4: A load reads the word at S into the accumulator in its execute cycle. Its execute cycle and its fetch cycle make two memory reads.
- R5: A store writes the accumulator to address S with mem_rnw at 0. This is the only access that writes.
- R6: Add and subtract combine the accumulator with the word at S modulo 2^16. There is no carry or overflow flag.
- R7: A jump fetches its target instruction from S in its one and only cycle.
- R8: The non-negative jump is taken exactly when accumulator bit 15 is 0. When it is not taken, the same cycle fetches from the program counter.
- R9: The non-zero jump is taken exactly when the accumulator is not all zeros. When it is not taken, the same cycle fetches from the program counter.
- R10: Stop makes no memory request in its execute cycle or in any later cycle. halted rises on the following cycle and stays at 1 until reset.
- R11: Opcodes 8 to 15 leave the accumulator and memory unchanged. Their single cycle is the fetch of the next instruction.
- R12: From reset to halted, the number of cycles equals the number of memory accesses plus one, for the stop's execute cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address |
| mem_rdata | input | 16 | Data read from memory, valid in the same cycle |
| mem_wdata | output | 16 | Data to write, the accumulator during a store, otherwise 0 |
| mem_req | output | 1 | Memory access in this cycle |
| mem_rnw | output | 1 | 1 for a read, 0 for a write |
| halted | output | 1 | Set after a stop instruction, cleared by reset |

## Verification
The arithmetic sweep pairs boundary values (0, 1, 0x7FFF, 0x8000, 0xFFFF). A design that kept a carry, or that subtracted in the wrong direction, would store wrong sums and differences.

Both conditional jumps are swept across the sign boundary and across zero. A design that tested the wrong bit, or that let an untaken branch skip a word, would execute the wrong path.

The bench compares the full address sequence of one program and the cycle count of every program. This exposes a program counter that fails to increment, and a jump or unused opcode that wastes an extra cycle.

After a stop, the bench watches the port for many cycles. This catches a core that keeps requesting memory or lets halted drop.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 4'd0,
        OP_STORE = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_JUMP  = 4'd4,
        OP_JPOS  = 4'd5,
        OP_JNZ   = 4'd6,
        OP_STOP  = 4'd7
    } opcode_t;

    typedef enum logic {
        PH_EXEC  = 1'b0,
        PH_FETCH = 1'b1
    } phase_t;

    typedef enum logic [2:0] {
        ALU_ZERO,
        ALU_PASSB,
        ALU_INCB,
        ALU_ADD,
        ALU_SUB
    } alu_fn_t;

    typedef enum logic {
        ASEL_PC,
        ASEL_OPND
    } asel_t;

    typedef enum logic {
        BSRC_DATA,
        BSRC_ADDR
    } bsrc_t;

    typedef struct packed {
        logic a_en;
        logic b_zero;
        logic b_inv;
        logic cin;
    } alu_ctl_t;

    typedef struct packed {
        asel_t   asel;
        bsrc_t   bsel;
        alu_fn_t fn;
        logic    acc_we;
        logic    pc_we;
        logic    ir_we;
        logic    drive;
        logic    req;
        logic    rnw;
        logic    halt_set;
        phase_t  nxt_phase;
    } ctl_t;

    function automatic alu_ctl_t alu_decode(input alu_fn_t fn);
        alu_ctl_t c;
        c = '{a_en: 1'b0, b_zero: 1'b0, b_inv: 1'b0, cin: 1'b0};
        case (fn)
            ALU_ZERO:  c.b_zero = 1'b1;
            ALU_PASSB: c = c;
            ALU_INCB:  c.cin = 1'b1;
            ALU_ADD:   c.a_en = 1'b1;
            ALU_SUB:   begin c.a_en = 1'b1; c.b_inv = 1'b1; c.cin = 1'b1; end
            default:   c.b_zero = 1'b1;
        endcase
        return c;
    endfunction

    function automatic ctl_t idle_ctl(input phase_t hold);
        ctl_t c;
        c.asel      = ASEL_PC;
        c.bsel      = BSRC_ADDR;
        c.fn        = ALU_PASSB;
        c.acc_we    = 1'b0;
        c.pc_we     = 1'b0;
        c.ir_we     = 1'b0;
        c.drive     = 1'b0;
        c.req       = 1'b0;
        c.rnw       = 1'b1;
        c.halt_set  = 1'b0;
        c.nxt_phase = hold;
        return c;
    endfunction

    function automatic ctl_t fetch_ctl(input asel_t src);
        ctl_t c;
        c = idle_ctl(PH_EXEC);
        c.asel  = src;
        c.bsel  = BSRC_ADDR;
        c.fn    = ALU_INCB;
        c.req   = 1'b1;
        c.ir_we = 1'b1;
        c.pc_we = 1'b1;
        return c;
    endfunction

    function automatic ctl_t operand_ctl(input alu_fn_t fn, input logic wr);
        ctl_t c;
        c = idle_ctl(PH_FETCH);
        c.asel   = ASEL_OPND;
        c.bsel   = BSRC_DATA;
        c.fn     = fn;
        c.req    = 1'b1;
        c.rnw    = ~wr;
        c.drive  = wr;
        c.acc_we = ~wr;
        return c;
    endfunction

endpackage

// File: rtl/acc16_alu.sv
module acc16_alu
    import acc16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_t      fn,
    output logic [W-1:0] y
);
    alu_ctl_t     c;
    logic [W-1:0] a_g;
    logic [W-1:0] b_g;
    logic [W-1:0] b_x;

    always_comb begin
        c   = alu_decode(fn);
        a_g = c.a_en ? a : '0;
        b_g = c.b_zero ? '0 : b;
        b_x = c.b_inv ? ~b_g : b_g;
        y   = a_g + b_x + {{(W-1){1'b0}}, c.cin};
    end

    always_comb begin
        if (fn == ALU_ZERO) begin
            a_zero_r1 : assert (y == '0);
        end
    end
endmodule

// File: rtl/acc16_ctrl.sv
module acc16_ctrl
    import acc16_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            acc_neg,
    input  logic            acc_zero,
    output ctl_t            ctl,
    output logic            halted
);
    phase_t phase_q;

    always_comb begin
        ctl = idle_ctl(phase_q);
        if (rst) begin
            ctl.fn        = ALU_ZERO;
            ctl.pc_we     = 1'b1;
            ctl.acc_we    = 1'b1;
            ctl.nxt_phase = PH_FETCH;
        end else if (phase_q == PH_FETCH) begin
            ctl = fetch_ctl(ASEL_PC);
        end else begin
            case (opcode)
                OP_LOAD:  ctl = operand_ctl(ALU_PASSB, 1'b0);
                OP_STORE: ctl = operand_ctl(ALU_PASSB, 1'b1);
                OP_ADD:   ctl = operand_ctl(ALU_ADD, 1'b0);
                OP_SUB:   ctl = operand_ctl(ALU_SUB, 1'b0);
                OP_JUMP:  ctl = fetch_ctl(ASEL_OPND);
                OP_JPOS:  ctl = fetch_ctl(acc_neg ? ASEL_PC : ASEL_OPND);
                OP_JNZ:   ctl = fetch_ctl(acc_zero ? ASEL_PC : ASEL_OPND);
                OP_STOP:  ctl.halt_set = 1'b1;
                default:  ctl = fetch_ctl(ASEL_PC);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
            halted  <= 1'b0;
        end else begin
            phase_q <= ctl.nxt_phase;
            if (ctl.halt_set) halted <= 1'b1;
        end
    end

    p_fetch_then_exec_r2 : assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));

    p_halt_sticky_r10 : assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_no_req_r10 : assert property (@(posedge clk) disable iff (rst)
        halted |-> !ctl.req);

    p_unused_noop_r11 : assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC && opcode[OP_W-1]) |-> (!ctl.acc_we && ctl.rnw && ctl.asel == ASEL_PC));
endmodule

// File: rtl/acc16_core.sv
module acc16_core
    import acc16_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic [ADDR_W+OP_W-1:0] mem_rdata,
    output logic [ADDR_W+OP_W-1:0] mem_wdata,
    output logic                   mem_req,
    output logic                   mem_rnw,
    output logic                   halted
);
    localparam int DATA_W = ADDR_W + OP_W;

    logic [DATA_W-1:0] acc_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [ADDR_W-1:0] opnd;
    logic [OP_W-1:0]   opcode;
    logic [DATA_W-1:0] alu_b;
    logic [DATA_W-1:0] alu_y;
    logic              acc_zero;
    ctl_t              ctl;

    assign opnd     = ir_q[ADDR_W-1:0];
    assign opcode   = ir_q[DATA_W-1 -: OP_W];
    assign acc_zero = (acc_q == '0);

    acc16_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .acc_neg  (acc_q[DATA_W-1]),
        .acc_zero (acc_zero),
        .ctl      (ctl),
        .halted   (halted)
    );

    assign mem_addr  = (ctl.asel == ASEL_PC) ? pc_q : opnd;
    assign mem_req   = ctl.req;
    assign mem_rnw   = ctl.rnw;
    assign mem_wdata = ctl.drive ? acc_q : '0;
    assign alu_b     = (ctl.bsel == BSRC_DATA) ? mem_rdata
                                               : {{OP_W{1'b0}}, mem_addr};

    acc16_alu #(.W(DATA_W)) u_alu (
        .a  (acc_q),
        .b  (alu_b),
        .fn (ctl.fn),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (ctl.acc_we) acc_q <= alu_y;
        if (ctl.pc_we)  pc_q  <= alu_y[ADDR_W-1:0];
        if (rst)             ir_q <= '0;
        else if (ctl.ir_we)  ir_q <= mem_rdata;
    end

    p_reset_pc_zero_r1 : assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == '0 && acc_q == '0));

    p_fetch_increment_r2 : assert property (@(posedge clk) disable iff (rst)
        (mem_req && ctl.ir_we) |=> (pc_q == ADDR_W'($past(mem_addr) + 1'b1)));

    p_store_data_r5 : assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rnw) |-> (mem_wdata == acc_q && mem_addr == opnd));

    p_halt_frozen_r10 : assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(acc_q) && $stable(pc_q) && $stable(ir_q)));
endmodule

// File: tb/sim_acc16_core.sv
`timescale 1ns/1ps
module sim_acc16_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_req;
    logic        mem_rnw;
    logic        halted;

    logic [15:0] mem [0:255];
    int          checks = 0;
    int          errors = 0;
    logic [11:0] seq_a [0:31];
    logic        seq_w [0:31];
    int          seq_n;

    always #2 clk = ~clk;

    acc16_core u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_req(mem_req), .mem_rnw(mem_rnw), .halted(halted)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_req && !mem_rnw) mem[mem_addr[7:0]] <= mem_wdata;

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] s);
        return {op, s};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic run_prog(output int cyc, output int reqs);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(mem_req == 1'b0 && halted == 1'b0, "R1 reset idle", {mem_req, halted}, 0);
        rst  = 1'b0;
        cyc  = 0;
        reqs = 0;
        seq_n = 0;
        forever begin
            #1;
            if (halted || cyc > 1000) break;
            if (mem_req) begin
                if (seq_n < 32) begin
                    seq_a[seq_n] = mem_addr;
                    seq_w[seq_n] = !mem_rnw;
                    seq_n++;
                end
                reqs++;
            end
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        int cyc, reqs;
        logic [15:0] vals [0:7];
        logic [11:0] exp_a [0:12];
        vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hFEDC};
        exp_a = '{12'h000, 12'h080, 12'h001, 12'h081, 12'h002, 12'h082, 12'h003,
                  12'h080, 12'h004, 12'h081, 12'h005, 12'h083, 12'h006};

        // R4 R5 R6 R12: arithmetic sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                clear_mem();
                mem[0] = ins(4'd0, 12'h080); mem[1] = ins(4'd2, 12'h081);
                mem[2] = ins(4'd1, 12'h082); mem[3] = ins(4'd0, 12'h080);
                mem[4] = ins(4'd3, 12'h081); mem[5] = ins(4'd1, 12'h083);
                mem[6] = ins(4'd7, 12'h000);
                mem[8'h80] = vals[i]; mem[8'h81] = vals[j];
                run_prog(cyc, reqs);
                check(mem[8'h82] == 16'(vals[i] + vals[j]), "R6 add", mem[8'h82], 16'(vals[i] + vals[j]));
                check(mem[8'h83] == 16'(vals[i] - vals[j]), "R6 sub", mem[8'h83], 16'(vals[i] - vals[j]));
                check(mem[8'h80] == vals[i] && mem[8'h81] == vals[j], "R5 only store writes",
                      {mem[8'h80], mem[8'h81]}, {vals[i], vals[j]});
                check(cyc == 14 && reqs == 13, "R12 cycles", {cyc[15:0], reqs[15:0]}, {16'd14, 16'd13});
                if (i == 0 && j == 0) begin
                    check(seq_n == 13, "R2 access count", seq_n, 13);
                    for (int k = 0; k < 13; k++) begin
                        check(seq_a[k] == exp_a[k], "R1 R2 R3 R4 address order", seq_a[k], exp_a[k]);
                        check(seq_w[k] == (k == 5 || k == 11), "R5 write strobe", seq_w[k], (k == 5 || k == 11));
                    end
                end
            end
        end

        // R8 R9: conditional jump sweep
        for (int op = 5; op <= 6; op++) begin
            for (int i = 0; i < 8; i++) begin
                bit taken;
                clear_mem();
                mem[0] = ins(4'd0, 12'h080); mem[1] = ins(4'(op), 12'h005);
                mem[2] = ins(4'd0, 12'h081); mem[3] = ins(4'd1, 12'h082);
                mem[4] = ins(4'd7, 12'h000); mem[5] = ins(4'd0, 12'h083);
                mem[6] = ins(4'd1, 12'h082); mem[7] = ins(4'd7, 12'h000);
                mem[8'h80] = vals[i]; mem[8'h81] = 16'h1111; mem[8'h83] = 16'h2222;
                taken = (op == 5) ? (vals[i][15] == 1'b0) : (vals[i] != 16'h0000);
                run_prog(cyc, reqs);
                check(mem[8'h82] == (taken ? 16'h2222 : 16'h1111), op == 5 ? "R8 jpos path" : "R9 jnz path",
                      mem[8'h82], taken ? 16'h2222 : 16'h1111);
                check(cyc == 9 && reqs == 8, "R8 R9 R12 branch cycles", {cyc[15:0], reqs[15:0]}, {16'd9, 16'd8});
            end
        end

        // R7: unconditional jump
        clear_mem();
        mem[0] = ins(4'd4, 12'h010); mem[1] = ins(4'd0, 12'h081);
        mem[2] = ins(4'd1, 12'h082); mem[3] = ins(4'd7, 12'h000);
        mem[16] = ins(4'd0, 12'h083); mem[17] = ins(4'd1, 12'h082); mem[18] = ins(4'd7, 12'h000);
        mem[8'h81] = 16'h1111; mem[8'h83] = 16'h2222;
        run_prog(cyc, reqs);
        check(mem[8'h82] == 16'h2222, "R7 jump target", mem[8'h82], 16'h2222);
        check(cyc == 7 && reqs == 6, "R7 jump one cycle", {cyc[15:0], reqs[15:0]}, {16'd7, 16'd6});
        check(seq_a[1] == 12'h010, "R7 target fetch", seq_a[1], 12'h010);

        // R11: unused opcodes
        for (int op = 8; op < 16; op++) begin
            clear_mem();
            mem[0] = ins(4'd0, 12'h080); mem[1] = ins(4'(op), 12'h081);
            mem[2] = ins(4'd1, 12'h082); mem[3] = ins(4'd7, 12'h000);
            mem[8'h80] = 16'h1234; mem[8'h81] = 16'h5555;
            run_prog(cyc, reqs);
            check(mem[8'h82] == 16'h1234, "R11 acc kept", mem[8'h82], 16'h1234);
            check(mem[8'h81] == 16'h5555, "R11 memory kept", mem[8'h81], 16'h5555);
            check(cyc == 7 && reqs == 6, "R11 one cycle", {cyc[15:0], reqs[15:0]}, {16'd7, 16'd6});
        end

        // R10: halt holds, reset clears
        begin
            int bad = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk); #1;
                if (mem_req || !halted) bad++;
            end
            check(bad == 0, "R10 halt held without requests", bad, 0);
            check(mem[8'h82] == 16'h1234, "R10 no write after stop", mem[8'h82], 16'h1234);
        end
        rst = 1'b1;
        @(negedge clk); #1;
        check(halted == 1'b0 && mem_req == 1'b0, "R1 R10 reset clears halt", {halted, mem_req}, 0);
        rst = 1'b0;
        #1;
        check(mem_req && mem_rnw && mem_addr == 12'h000, "R1 first fetch at zero",
              {mem_req, mem_rnw, mem_addr}, {2'b11, 12'h000});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule